// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Polarity and Alignment Control

This block produces four pulse-width modulated waveforms from one shared clock divider. Every channel keeps its own up/down counter, a period and a duty value, a bit that picks which output level opens each period, and a bit that picks edge-aligned or symmetric (center) counting. Software programs the block through a small byte-wide register port with a single address bus. Reads are combinational, and writes take effect on the rising clock edge.

A channel that is producing a waveform takes over its pin. It forces the pin's output enable on, whatever the software direction bit holds, and it does not change that bit. When the channel stops, the direction bit and the general-purpose data bit govern the pin again.

Each channel is a four-state machine:

- **CH_IDLE**: stopped.
- **CH_ARM**: enabled, waiting for the next period boundary.
- **CH_UP**: counting up.
- **CH_DOWN**: counting down, used in center mode only.

States change only on a divider tick. The transitions are:

- CH_IDLE goes to CH_ARM on a tick when the channel is enabled.
- CH_ARM goes to CH_UP on the next tick. This tick latches the period, duty and mode into a shadow copy and clears the counter.
- CH_UP wraps back to CH_UP at the end of an edge-aligned period. In center mode, CH_UP goes to CH_DOWN once the counter reaches period-1.
- CH_DOWN goes back to CH_UP after it reaches 1. This is a new period boundary, and the shadow copy reloads.
- Any state goes to CH_IDLE on a tick when the channel's enable bit is 0.

The divider counts only while some channel is enabled or still running.

Top module: `pwm4_unit`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` is 0 and `pin_out` is 0.
- R2: The register map is:
  - 0x0: enable.
  - 0x1: polarity.
  - 0x2: center mode.
  - 0x3: divider DIV.
  - 0x4+i: period of channel i.
  - 0x8+i: duty of channel i.
  - 0xC: direction.
  - 0xD: general-purpose data.
  - 0xE: divider count, read-only.

  In the 4-bit registers, bit i belongs to channel i and the upper bits read 0. Unused addresses read 0.
- R3: In edge mode with polarity 0, a period lasts P+1 ticks. The output is low for the first D ticks and high for the rest. If D > P, the output is low for the whole period.
- R4: In edge mode with polarity 1, the output is high for the first D ticks of each P+1-tick period and low for the rest.
- R5: In center mode, with 1 ≤ P and D ≤ P, a period lasts 2P ticks. The output holds the polarity's opening level for the first D ticks and for the last D ticks (2D ticks in total) and holds the opposite level in between.
- R6: While a channel runs, its `pin_oe` is 1 and its `pin_out` follows the waveform, whatever the direction and data bits hold. Enabling a channel does not alter the direction register's read value.
- R7: After the enable write, the channel takes over the pin only at a period start. With DIV=0, `pin_oe` stays 0 in the two cycles after the write edge, and the third cycle is period position 0.
- R8: When the enable bit clears, the channel stops at the next tick. The pin is then driven by the direction bit (`pin_oe`) and the data bit (`pin_out`).
- R9: Writes to the period or duty register while a channel runs leave the current period untouched and apply from the next period start.
- R10: With the divider running, a tick occurs every DIV+1 clocks, and channel state changes only on ticks. Each tick of waveform therefore lasts DIV+1 clocks.
- R11: When all enable bits are 0 and no channel is running, the divider count (read at 0xE) holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | AW (4) | Register address for reads and writes |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Combinational read data at `bus_addr` |
| pin_out | output | CH_N (4) | Pin data: waveform when running, else general-purpose data bit |
| pin_oe | output | CH_N (4) | Pin output enable: 1 when running, else direction bit |

## Verification
A channel machine stuck in the wrong state shows up within one tick as a pin whose output enable rises too early or too late. A counter that is off by one shows up within a single period as a high or low run of the wrong length. A shadow copy that reloads at the wrong moment shows up as a changed pulse inside the period in which the register was written, instead of one period later. A divider that keeps running with every channel off shows up as a moving count at the read-only address within a few clocks.

// File: rtl/pwm4_pkg.sv
`timescale 1ns/1ps
package pwm4_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_ARM  = 2'd1,
        CH_UP   = 2'd2,
        CH_DOWN = 2'd3
    } ch_state_t;

    localparam int A_EN   = 0;
    localparam int A_POL  = 1;
    localparam int A_CTR  = 2;
    localparam int A_DIV  = 3;
    localparam int A_PER  = 4;
    localparam int A_DUTY = 8;
    localparam int A_DDR  = 12;
    localparam int A_GPO  = 13;
    localparam int A_PRE  = 14;
endpackage

// File: rtl/pwm4_regs.sv
`timescale 1ns/1ps
module pwm4_regs
    import pwm4_pkg::*;
#(
    parameter int CH_N = 4,
    parameter int DW   = 8,
    parameter int AW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   pre_cnt,
    output logic [CH_N-1:0] en,
    output logic [CH_N-1:0] pol,
    output logic [CH_N-1:0] ctr,
    output logic [CH_N-1:0] ddr,
    output logic [CH_N-1:0] gpo,
    output logic [DW-1:0]   div,
    output logic [DW-1:0]   period [CH_N],
    output logic [DW-1:0]   duty   [CH_N],
    output logic [DW-1:0]   rdata
);
    // Register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en  <= '0;
            pol <= '0;
            ctr <= '0;
            ddr <= '0;
            gpo <= '0;
            div <= '0;
            for (int i = 0; i < CH_N; i++) begin
                period[i] <= '0;
                duty[i]   <= '0;
            end
        end else if (wr) begin
            if (addr == AW'(A_EN))  en  <= wdata[CH_N-1:0];
            if (addr == AW'(A_POL)) pol <= wdata[CH_N-1:0];
            if (addr == AW'(A_CTR)) ctr <= wdata[CH_N-1:0];
            if (addr == AW'(A_DDR)) ddr <= wdata[CH_N-1:0];
            if (addr == AW'(A_GPO)) gpo <= wdata[CH_N-1:0];
            if (addr == AW'(A_DIV)) div <= wdata;
            for (int i = 0; i < CH_N; i++) begin
                if (addr == AW'(A_PER + i))  period[i] <= wdata;
                if (addr == AW'(A_DUTY + i)) duty[i]   <= wdata;
            end
        end
    end

    // Read mux, zero for unmapped addresses
    always_comb begin
        rdata = '0;
        if (addr == AW'(A_EN))  rdata = DW'(en);
        if (addr == AW'(A_POL)) rdata = DW'(pol);
        if (addr == AW'(A_CTR)) rdata = DW'(ctr);
        if (addr == AW'(A_DDR)) rdata = DW'(ddr);
        if (addr == AW'(A_GPO)) rdata = DW'(gpo);
        if (addr == AW'(A_DIV)) rdata = div;
        if (addr == AW'(A_PRE)) rdata = pre_cnt;
        for (int i = 0; i < CH_N; i++) begin
            if (addr == AW'(A_PER + i))  rdata = period[i];
            if (addr == AW'(A_DUTY + i)) rdata = duty[i];
        end
    end
endmodule

// File: rtl/pwm4_prescaler.sv
`timescale 1ns/1ps
module pwm4_prescaler #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick,
    output logic [DW-1:0] cnt
);
    logic at_top;

    assign at_top = (cnt >= div);
    assign tick   = run && at_top;

    // Counter holds its value while no channel needs it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= at_top ? '0 : cnt + DW'(1);
        end
    end
endmodule

// File: rtl/pwm4_chan.sv
`timescale 1ns/1ps
module pwm4_chan
    import pwm4_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          pol,
    input  logic          ctr,
    input  logic [DW-1:0] per_in,
    input  logic [DW-1:0] duty_in,
    output logic          active,
    output logic          busy,
    output logic [DW-1:0] cnt,
    output logic          pwm
);
    ch_state_t     st, st_n;
    logic [DW-1:0] cnt_n;
    logic [DW-1:0] sh_per, sh_duty;
    logic          sh_ctr;
    logic          load;
    logic          open_phase;

    // Next-state logic: moves only on a divider tick
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        load  = 1'b0;
        if (tick) begin
            unique case (st)
                CH_IDLE: begin
                    if (en) st_n = CH_ARM;
                end
                CH_ARM: begin
                    if (!en) begin
                        st_n = CH_IDLE;
                    end else begin
                        st_n  = CH_UP;
                        cnt_n = '0;
                        load  = 1'b1;
                    end
                end
                CH_UP: begin
                    if (!en) begin
                        st_n  = CH_IDLE;
                        cnt_n = '0;
                    end else if (sh_ctr && (sh_per != '0) && (cnt == sh_per - DW'(1))) begin
                        st_n  = CH_DOWN;
                        cnt_n = sh_per;
                    end else if (cnt >= sh_per) begin
                        cnt_n = '0;
                        load  = 1'b1;
                    end else begin
                        cnt_n = cnt + DW'(1);
                    end
                end
                CH_DOWN: begin
                    if (!en) begin
                        st_n  = CH_IDLE;
                        cnt_n = '0;
                    end else if (cnt <= DW'(1)) begin
                        st_n  = CH_UP;
                        cnt_n = '0;
                        load  = 1'b1;
                    end else begin
                        cnt_n = cnt - DW'(1);
                    end
                end
            endcase
        end
    end

    // State register with period-boundary shadow load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= CH_IDLE;
            cnt     <= '0;
            sh_per  <= '0;
            sh_duty <= '0;
            sh_ctr  <= 1'b0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if (load) begin
                sh_per  <= per_in;
                sh_duty <= duty_in;
                sh_ctr  <= ctr;
            end
        end
    end

    // Outputs
    always_comb begin
        active     = (st == CH_UP) || (st == CH_DOWN);
        busy       = (st != CH_IDLE);
        open_phase = (st == CH_DOWN) ? (cnt <= sh_duty) : (cnt < sh_duty);
        pwm        = pol ? open_phase : !open_phase;
    end
endmodule

// File: rtl/pwm4_unit.sv
`timescale 1ns/1ps
module pwm4_unit #(
    parameter int CH_N = 4,
    parameter int DW   = 8,
    parameter int AW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [CH_N-1:0] pin_out,
    output logic [CH_N-1:0] pin_oe
);
    localparam int CW_ALL = CH_N * DW;

    logic [CH_N-1:0]   en_r, pol_r, ctr_r, ddr_r, gpo_r;
    logic [DW-1:0]     div_r;
    logic [DW-1:0]     period [CH_N];
    logic [DW-1:0]     duty   [CH_N];
    logic [DW-1:0]     pre_cnt;
    logic              tick;
    logic              run;
    logic [CH_N-1:0]   active, busy, pwm;
    logic [CW_ALL-1:0] cnt_flat;

    pwm4_regs #(.CH_N(CH_N), .DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .pre_cnt (pre_cnt),
        .en      (en_r),
        .pol     (pol_r),
        .ctr     (ctr_r),
        .ddr     (ddr_r),
        .gpo     (gpo_r),
        .div     (div_r),
        .period  (period),
        .duty    (duty),
        .rdata   (bus_rdata)
    );

    assign run = (|en_r) | (|busy);

    pwm4_prescaler #(.DW(DW)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_r),
        .tick  (tick),
        .cnt   (pre_cnt)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        pwm4_chan #(.DW(DW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .en      (en_r[g]),
            .pol     (pol_r[g]),
            .ctr     (ctr_r[g]),
            .per_in  (period[g]),
            .duty_in (duty[g]),
            .active  (active[g]),
            .busy    (busy[g]),
            .cnt     (cnt_flat[g*DW +: DW]),
            .pwm     (pwm[g])
        );
        assign pin_oe[g]  = active[g] | ddr_r[g];
        assign pin_out[g] = active[g] ? pwm[g] : gpo_r[g];
    end
endmodule

// File: rtl/pwm4_checker.sv
`timescale 1ns/1ps
module pwm4_checker #(
    parameter int CH_N = 4,
    parameter int DW   = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic [CH_N-1:0]      en,
    input logic [CH_N-1:0]      busy,
    input logic [CH_N-1:0]      active,
    input logic [CH_N*DW-1:0]   cnt_flat,
    input logic [DW-1:0]        pre_cnt,
    input logic [CH_N-1:0]      pin_oe
);
    assert_quiet_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt_flat) && $stable(busy) && $stable(active)));

    assert_prescaler_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((en == '0) && (busy == '0)) |=> $stable(pre_cnt));

    for (genvar i = 0; i < CH_N; i++) begin : g_chk
        assert_start_after_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(active[i]) |-> $past(busy[i] && !active[i]));

        assert_disable_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !en[i] && busy[i]) |=> !busy[i]);

        assert_pin_takeover_R6: assert property (@(posedge clk) disable iff (!rst_n)
            active[i] |-> pin_oe[i]);
    end
endmodule

bind pwm4_unit pwm4_checker #(.CH_N(CH_N), .DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .en       (en_r),
    .busy     (busy),
    .active   (active),
    .cnt_flat (cnt_flat),
    .pre_cnt  (pre_cnt),
    .pin_oe   (pin_oe)
);

// File: tb/pwm4_unit_tb_top.sv
`timescale 1ns/1ps
module pwm4_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_wr;
    logic [3:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    pwm4_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    typedef struct packed {
        logic [1:0] ch;
        logic       pol;
        logic       ctr;
        logic [7:0] per;
        logic [7:0] duty;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 8'd5, 8'd2},
        '{2'd1, 1'b1, 1'b0, 8'd4, 8'd1},
        '{2'd2, 1'b0, 1'b1, 8'd3, 8'd1},
        '{2'd3, 1'b1, 1'b1, 8'd4, 8'd2},
        '{2'd0, 1'b1, 1'b0, 8'd3, 8'd0},
        '{2'd1, 1'b0, 1'b0, 8'd3, 8'd4},
        '{2'd2, 1'b1, 1'b1, 8'd2, 8'd2}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Caller sits at a falling edge; returns at the next falling edge
    task automatic put(input logic [3:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic get(input logic [3:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // Expected level at position n of a period
    function automatic logic exp_lvl(input logic pol, input logic ctr,
                                     input int per, input int duty, input int n);
        logic open_ph;
        if (ctr) open_ph = (n < duty) || (n >= 2 * per - duty);
        else     open_ph = (n < duty);
        return pol ? open_ph : !open_ph;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R10 actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        logic [7:0] rv2;
        vec_t       v;
        string      tag;
        int         len;
        int         hi_n;
        int         lo_n;
        rst_n     = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        repeat (4) @(negedge clk);
        check("R1 pin_oe in reset", int'(pin_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pin_oe after reset", int'(pin_oe), 0);
        check("R1 pin_out after reset", int'(pin_out), 0);
        for (int a = 0; a < 16; a++) begin
            get(4'(a), rv);
            check($sformatf("R1 reset read addr %0d", a), int'(rv), 0);
        end

        // R2 register map
        put(4'd2, 8'hFF);
        get(4'd2, rv);  check("R2 mode reg width", int'(rv), 8'h0F);
        put(4'd3, 8'hA5);
        get(4'd3, rv);  check("R2 divider reg", int'(rv), 8'hA5);
        put(4'd6, 8'h3C);
        get(4'd6, rv);  check("R2 period ch2", int'(rv), 8'h3C);
        put(4'd9, 8'h5A);
        get(4'd9, rv);  check("R2 duty ch1", int'(rv), 8'h5A);
        get(4'd15, rv); check("R2 unmapped read", int'(rv), 0);
        put(4'd2, 8'h00);
        put(4'd6, 8'h00);
        put(4'd9, 8'h00);

        // Waveform table walk (R3, R4, R5, R6, R7, R8)
        put(4'd3, 8'd0);
        for (int k = 0; k < NV; k++) begin
            v = VECS[k];
            if (v.ctr)      tag = "R5 center wave";
            else if (v.pol) tag = "R4 edge pol1 wave";
            else            tag = "R3 edge pol0 wave";
            len = v.ctr ? 2 * int'(v.per) : int'(v.per) + 1;
            put(4'd4 + 4'(v.ch), v.per);
            put(4'd8 + 4'(v.ch), v.duty);
            put(4'd1, 8'(v.pol) << v.ch);
            put(4'd2, 8'(v.ctr) << v.ch);
            put(4'd0, 8'd1 << v.ch);
            check($sformatf("R7 vec%0d not driven after write", k), int'(pin_oe[v.ch]), 0);
            @(negedge clk);
            check($sformatf("R7 vec%0d not driven while armed", k), int'(pin_oe[v.ch]), 0);
            @(negedge clk);
            check($sformatf("R6 vec%0d pin taken at start", k), int'(pin_oe[v.ch]), 1);
            for (int n = 0; n < 2 * len; n++) begin
                check($sformatf("%s vec%0d pos%0d", tag, k, n), int'(pin_out[v.ch]),
                      int'(exp_lvl(v.pol, v.ctr, int'(v.per), int'(v.duty), n % len)));
                @(negedge clk);
            end
            put(4'd0, 8'd0);
            repeat (3) @(negedge clk);
            check($sformatf("R8 vec%0d released", k), int'(pin_oe[v.ch]), 0);
        end

        // R6 / R8: override and hand-back of direction and data bits
        put(4'd1, 8'd0);
        put(4'd2, 8'd0);
        put(4'd4, 8'd3);
        put(4'd8, 8'd5);
        put(4'd0, 8'd1);
        repeat (2) @(negedge clk);
        put(4'd12, 8'd1);
        put(4'd13, 8'd1);
        check("R6 oe while running", int'(pin_oe[0]), 1);
        check("R6 out ignores data bit", int'(pin_out[0]), 0);
        get(4'd12, rv);
        check("R6 direction reg unchanged", int'(rv), 1);
        put(4'd0, 8'd0);
        @(negedge clk);
        check("R8 oe from direction bit", int'(pin_oe[0]), 1);
        check("R8 out from data bit", int'(pin_out[0]), 1);
        put(4'd13, 8'd0);
        check("R8 out follows data bit", int'(pin_out[0]), 0);
        put(4'd12, 8'd0);
        check("R8 oe follows direction bit", int'(pin_oe[0]), 0);

        // R9: shadowed period and duty
        put(4'd4, 8'd7);
        put(4'd8, 8'd2);
        put(4'd0, 8'd1);
        repeat (2) @(negedge clk);
        for (int n = 0; n <= 18; n++) begin
            logic e;
            if (n < 8)       e = (n >= 2);
            else if (n < 18) e = ((n - 8) >= 5);
            else             e = 1'b0;
            check($sformatf("R9 shadow pos%0d", n), int'(pin_out[0]), int'(e));
            if (n == 2)      put(4'd8, 8'd5);
            else if (n == 4) put(4'd4, 8'd9);
            else             @(negedge clk);
        end
        put(4'd0, 8'd0);
        repeat (3) @(negedge clk);

        // R10: divider stretches each tick to DIV+1 clocks
        put(4'd3, 8'd3);
        put(4'd5, 8'd1);
        put(4'd9, 8'd1);
        put(4'd1, 8'd2);
        put(4'd0, 8'd2);
        for (int w = 0; w < 40 && pin_out[1] !== 1'b1; w++) @(negedge clk);
        hi_n = 0;
        for (int w = 0; w < 40 && pin_out[1] === 1'b1; w++) begin hi_n++; @(negedge clk); end
        lo_n = 0;
        for (int w = 0; w < 40 && pin_out[1] === 1'b0; w++) begin lo_n++; @(negedge clk); end
        check("R10 high run clocks", hi_n, 4);
        check("R10 low run clocks", lo_n, 4);
        get(4'd14, rv);
        @(negedge clk);
        get(4'd14, rv2);
        check("R10 divider counts while running", int'(rv != rv2), 1);

        // R11: divider halts when everything is off
        put(4'd0, 8'd0);
        repeat (10) @(negedge clk);
        check("R11 channel stopped", int'(pin_oe[1]), 0);
        get(4'd14, rv);
        repeat (5) @(negedge clk);
        get(4'd14, rv2);
        check("R11 divider count held", int'(rv2), int'(rv));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule